// File: doc/BRIEF.md
# Register Statistics Block Collector

On each trigger, this block reads a fixed, ordered set of fifteen module registers. It uses a simple register read port: a request with an address, answered by an acknowledge that carries the data and an error indication. Each result becomes a 32-bit word, with the register address in the upper half and the returned data in the lower half. All fifteen words are held in a local buffer.

When the last read is done, the block emits a statistics data block. The header word goes first, followed by the payload words. The header carries the statistics type code, a flag for any read error, a flag for any read timeout, and the payload length in bytes. Because the header holds the final state of both flags, it can only be formed once every read has finished. This is why the payload is buffered.

A per-read cycle counter limits how long the block waits for an acknowledge. A register that never answers is recorded as zero data, and the collection continues with the next register. The read bus and the contents of the registers are outside this block.

Top module: `regStatCollector`

## Requirements
- R1: During and right after reset, `rdReq`, `outValid` and `outLast` are low and `rdAddr` and `outData` are zero.
- R2: A `trigger` high at a clock edge while the block is idle starts a collection: from the next cycle, `rdReq` is high with `rdAddr` = 0x004B.
- R3: Registers are read in this order: 0x004B, 0x004C, 0x004D, then 0x4001 up to 0x400C. The next read is requested in the cycle after the previous one completes.
- R4: `rdReq` and `rdAddr` stay unchanged until an acknowledge or a timeout ends the read. `rdAddr` is zero whenever `rdReq` is low.
- R5: A read with no `rdAck` during `timeoutLimit` request cycles is abandoned. A limit of 0 behaves as 1. The stored data of that read is 0x0000 and the header timeout flag is set.
- R6: An `rdAck` together with `rdErr` sets the header error flag, and the returned data is stored unchanged. `rdErr` without `rdAck` has no effect.
- R7: An `rdAck` in the last permitted request cycle counts as a normal completion, not as a timeout.
- R8: In the cycle after the last read completes, `outValid` goes high for exactly 16 consecutive cycles. The header comes first, then the 15 words in read order. `outLast` is high only with the 16th word.
- R9: The header is laid out as follows: bits 31:28 = 0xF, bits 27:18 = 0, bit 17 = error flag, bit 16 = timeout flag, bits 15:0 = 60 (payload bytes).
- R10: Each payload word holds the register address in bits 31:16 and the read data in bits 15:0.
- R11: A `trigger` that arrives during reads or emission is ignored. Both flags are cleared at the start of every collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigger | input | 1 | Starts a collection when the block is idle |
| timeoutLimit | input | TO_W | Request cycles allowed per read before it is abandoned |
| rdReq | output | 1 | Register read request |
| rdAddr | output | 16 | Address of the register being read |
| rdAck | input | 1 | Read acknowledge; completes the current read |
| rdErr | input | 1 | Error indication, qualified by `rdAck` |
| rdData | input | 16 | Read data, qualified by `rdAck` |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Header or payload word |
| outLast | output | 1 | Marks the final payload word |

## Verification
The bench targets the following corner cases and the faults that would expose a wrong design:
- **Acknowledge in the last permitted wait cycle.** A design with an off-by-one in the timeout would record zero data and raise the timeout flag.
- **Timeout limit of zero.** A design with a naive comparison would wait for a wrap-around of the counter instead of giving up after one cycle.
- **Stray error strobe.** `rdErr` pulses without `rdAck`; a design that samples `rdErr` unqualified would raise the error flag falsely.
- **Trigger while busy.** Triggers arrive in the middle of reads and during emission; a design that accepted them would restart the address sequence or cut the block short.
- **Flag clearing.** A clean collection follows one that timed out; a design that did not clear its flags would carry a stale timeout bit into the header.

// File: rtl/regStatPkg.sv
package regStatPkg;

  localparam int REG_COUNT = 15;
  localparam int LOW_COUNT = 3;
  localparam logic [15:0] LOW_BASE  = 16'h004B;
  localparam logic [15:0] HIGH_BASE = 16'h4001;
  localparam int IDX_W = $clog2(REG_COUNT + 1);
  localparam logic [3:0] STAT_TYPE = 4'hF;
  localparam logic [15:0] PAYLOAD_BYTES = 16'(4 * REG_COUNT);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EMIT
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             clear;     // new collection begins
    logic             capture;   // current read ends this cycle
    logic             timedOut;  // ... and it ended by timeout
    logic             errSeen;   // ... and it was acknowledged with error
    logic             emitting;  // output word is valid
    logic             emitFirst; // output word is the header
    logic [IDX_W-1:0] slot;      // read slot or emit position
  } pathCtrl_t;

  function automatic logic [15:0] addrOf(input logic [IDX_W-1:0] idx);
    if (int'(idx) < LOW_COUNT) return LOW_BASE + 16'(idx);
    return HIGH_BASE + 16'(idx) - 16'(LOW_COUNT);
  endfunction

endpackage

// File: rtl/regStatCtrl.sv
module regStatCtrl
  import regStatPkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigger,
  input  logic [TO_W-1:0] timeoutLimit,
  input  logic            rdAck,
  input  logic            rdErr,
  output logic            rdReq,
  output logic [15:0]     rdAddr,
  output logic            outValid,
  output logic            outLast,
  output pathCtrl_t       strobe
);

  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic [TO_W-1:0]  waitCnt;
  logic [TO_W:0]    waitNext;
  logic             expire;
  logic             done;
  logic             lastRead;
  logic             lastEmit;

  // A limit of zero compares like a limit of one
  assign waitNext = {1'b0, waitCnt} + (TO_W + 1)'(1);
  assign expire   = waitNext >= {1'b0, timeoutLimit};
  assign done     = (phase == ST_READ) && (rdAck || expire);
  assign lastRead = idx == IDX_W'(REG_COUNT - 1);
  assign lastEmit = idx == IDX_W'(REG_COUNT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      idx     <= '0;
      waitCnt <= '0;
    end else begin
      unique case (phase)
        ST_IDLE: begin
          if (trigger) begin
            phase   <= ST_READ;
            idx     <= '0;
            waitCnt <= '0;
          end
        end
        ST_READ: begin
          if (done) begin
            waitCnt <= '0;
            if (lastRead) begin
              phase <= ST_EMIT;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_EMIT: begin
          if (lastEmit) begin
            phase <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rdReq    = phase == ST_READ;
    rdAddr   = rdReq ? addrOf(idx) : 16'h0000;
    outValid = phase == ST_EMIT;
    outLast  = outValid && lastEmit;

    strobe           = '0;
    strobe.clear     = (phase == ST_IDLE) && trigger;
    strobe.capture   = done;
    strobe.timedOut  = done && !rdAck;
    strobe.errSeen   = done && rdAck && rdErr;
    strobe.emitting  = outValid;
    strobe.emitFirst = outValid && (idx == '0);
    strobe.slot      = idx;
  end

  // R4: an open read keeps its request and address
  a_r4_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck && !expire |=> rdReq && $stable(rdAddr));

  // R5: an expired read is not requested again
  a_r5_single_timeout: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && expire && !rdAck |=> !rdReq || !$stable(rdAddr));

  // R8: emission directly follows the last read and never overlaps it
  a_r8_emit_follows_reads: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdReq) |-> outValid);

  a_r8_burst_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |=> outValid && !rdReq);

  // R11: a trigger during emission does not restart reads
  a_r11_busy_ignores_trigger: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast && trigger |=> !rdReq);

endmodule

// File: rtl/regStatPath.sv
module regStatPath
  import regStatPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  pathCtrl_t   strobe,
  input  logic [15:0] rdAddr,
  input  logic [15:0] rdData,
  output logic [31:0] outData
);

  logic [31:0]      words [REG_COUNT];
  logic             errFlag;
  logic             toFlag;
  logic [31:0]      header;
  logic [IDX_W-1:0] readSlot;

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      words[strobe.slot] <= {rdAddr, strobe.timedOut ? 16'h0000 : rdData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else if (strobe.clear) begin
      errFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (strobe.errSeen)  errFlag <= 1'b1;
      if (strobe.timedOut) toFlag  <= 1'b1;
    end
  end

  assign header   = {STAT_TYPE, 10'b0, errFlag, toFlag, PAYLOAD_BYTES};
  assign readSlot = strobe.slot - 1'b1;

  always_comb begin
    if (!strobe.emitting)      outData = 32'h0;
    else if (strobe.emitFirst) outData = header;
    else                       outData = words[readSlot];
  end

  // R11: flags start clean after a new trigger is taken
  a_r11_flags_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !errFlag && !toFlag);

  // R10: every payload word carries an address from the list
  a_r10_payload_addr: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitting && !strobe.emitFirst |->
      ((outData[31:16] >= 16'h004B && outData[31:16] <= 16'h004D) ||
       (outData[31:16] >= 16'h4001 && outData[31:16] <= 16'h400C)));

  // R5: a timeout raises the flag that the header will carry
  a_r5_flag_follows_timeout: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.timedOut |=> toFlag);

endmodule

// File: rtl/regStatCollector.sv
module regStatCollector
  import regStatPkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trigger,
  input  logic [TO_W-1:0] timeoutLimit,
  output logic            rdReq,
  output logic [15:0]     rdAddr,
  input  logic            rdAck,
  input  logic            rdErr,
  input  logic [15:0]     rdData,
  output logic            outValid,
  output logic [31:0]     outData,
  output logic            outLast
);

  pathCtrl_t strobe;

  regStatCtrl #(.TO_W(TO_W)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .trigger      (trigger),
    .timeoutLimit (timeoutLimit),
    .rdAck        (rdAck),
    .rdErr        (rdErr),
    .rdReq        (rdReq),
    .rdAddr       (rdAddr),
    .outValid     (outValid),
    .outLast      (outLast),
    .strobe       (strobe)
  );

  regStatPath path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .outData (outData)
  );

endmodule

// File: tb/regStatCollector_test.sv
module regStatCollector_test;

  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 16;
  localparam int NREG = 15;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            trigger = 1'b0;
  logic [TO_W-1:0] timeoutLimit = 16'd8;
  logic            rdAck = 1'b0;
  logic            rdErr = 1'b0;
  logic [15:0]     rdData = 16'h0;
  logic            rdReq;
  logic [15:0]     rdAddr;
  logic            outValid;
  logic [31:0]     outData;
  logic            outLast;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regStatCollector #(.TO_W(TO_W)) uut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .timeoutLimit(timeoutLimit),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdAck(rdAck), .rdErr(rdErr), .rdData(rdData),
    .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  hung = 0;

  // Responder plan: ack delay per read (-1 never), error flag, data
  int          delayPlan [NREG];
  bit          errPlan   [NREG];
  logic [15:0] dataPlan  [NREG];

  // Behavioural reference: 0 idle, 1 reading, 2 emitting
  int          mPhase = 0;
  int          mIdx = 0;
  int          mWait = 0;
  int          mEmit = 0;
  bit          mErr = 0;
  bit          mTo = 0;
  logic [31:0] mWords [$];

  function automatic logic [15:0] refAddr(int i);
    if (i < 3) return 16'h004B + 16'(i);
    return 16'h4001 + 16'(i - 3);
  endfunction

  function automatic logic [31:0] refHeader();
    return {4'hF, 10'b0, mErr, mTo, 16'd60};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fillPlan(int s, int dly);
    for (int i = 0; i < NREG; i++) begin
      delayPlan[i] = dly;
      errPlan[i]   = 1'b0;
      dataPlan[i]  = 16'hA000 ^ 16'(s << 8) ^ 16'(i * 16'h0111);
    end
  endtask

  task automatic step(bit trig, string tag);
    int  lim;
    bit  done;
    if (hung) return;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      hung = 1;
      checks++;
      errors++;
      $display("FAIL watchdog (%s): actual %0d cycles expected at most %0d", tag, cycles, WATCHDOG);
      return;
    end
    // compare outputs with the reference
    check({tag, " R4 rdReq"}, 32'(rdReq), 32'(mPhase == 1));
    check({tag, " R3 rdAddr"}, 32'(rdAddr), mPhase == 1 ? 32'(refAddr(mIdx)) : 32'h0);
    check({tag, " R8 outValid"}, 32'(outValid), 32'(mPhase == 2));
    check({tag, " R8 outLast"}, 32'(outLast), 32'(mPhase == 2 && mEmit == NREG));
    if (mPhase == 2) begin
      if (mEmit == 0) check({tag, " R9 header"}, outData, refHeader());
      else            check({tag, " R10 word"}, outData, mWords[mEmit - 1]);
    end
    // drive inputs for the next edge
    trigger = trig;
    if (mPhase == 1 && delayPlan[mIdx] == mWait) begin
      rdAck  = 1'b1;
      rdErr  = errPlan[mIdx];
      rdData = dataPlan[mIdx];
    end else begin
      rdAck  = 1'b0;
      rdErr  = cycles[0]; // stray error without ack must be ignored (R6)
      rdData = 16'hDEAD;
    end
    // advance the reference across that edge
    case (mPhase)
      0: if (trig) begin
        mPhase = 1; mIdx = 0; mWait = 0; mErr = 0; mTo = 0;
        mWords.delete();
      end
      1: begin
        lim  = (timeoutLimit == 0) ? 1 : int'(timeoutLimit);
        done = 0;
        if (rdAck) begin
          mWords.push_back({refAddr(mIdx), rdData});
          if (rdErr) mErr = 1;
          done = 1;
        end else if (mWait + 1 >= lim) begin
          mWords.push_back({refAddr(mIdx), 16'h0000});
          mTo  = 1;
          done = 1;
        end else begin
          mWait++;
        end
        if (done) begin
          mWait = 0;
          if (mIdx == NREG - 1) begin
            mPhase = 2;
            mEmit  = 0;
          end else begin
            mIdx++;
          end
        end
      end
      default: begin
        if (mEmit == NREG) mPhase = 0;
        else mEmit++;
      end
    endcase
  endtask

  task automatic runCollection(string tag, bit busyTrig);
    int k;
    k = 0;
    step(1'b1, tag);
    while (mPhase != 0 && !hung) begin
      step(busyTrig && (k % 5 == 2), tag);
      k++;
    end
    step(1'b0, tag);
    step(1'b0, tag);
  endtask

  initial begin
    // R1: reset state
    fillPlan(0, 0);
    repeat (3) @(negedge clk);
    check("R1 rdReq", 32'(rdReq), 32'h0);
    check("R1 outValid", 32'(outValid), 32'h0);
    check("R1 outLast", 32'(outLast), 32'h0);
    check("R1 rdAddr", 32'(rdAddr), 32'h0);
    check("R1 outData", outData, 32'h0);
    rstN = 1'b1;
    step(1'b0, "R1 idle");

    // R2 R3: immediate acks
    timeoutLimit = 16'd8;
    fillPlan(1, 0);
    runCollection("R2 basic", 1'b0);

    // R6: varied delays, one error acknowledge
    fillPlan(2, 0);
    for (int i = 0; i < NREG; i++) delayPlan[i] = i % 4;
    errPlan[6] = 1'b1;
    runCollection("R6 error", 1'b0);

    // R5 R7: one silent register, one ack in the final permitted cycle
    timeoutLimit = 16'd4;
    fillPlan(3, 1);
    delayPlan[5] = -1;
    delayPlan[9] = 3;
    runCollection("R5 R7 timeout", 1'b0);

    // R5: zero limit behaves as one
    timeoutLimit = 16'd0;
    fillPlan(4, 0);
    delayPlan[0] = -1;
    runCollection("R5 zero limit", 1'b0);

    // R11: triggers while busy are ignored, flags cleared from previous run
    timeoutLimit = 16'd8;
    fillPlan(5, 2);
    runCollection("R11 busy trigger", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule